// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous static memory. Each word holds four byte lanes. All address, enable, strobe and write inputs are sampled on the rising clock edge. An access starts when either of two address strobes is sampled low. One strobe belongs to the processor side and the other to the memory controller side. The starting address is loaded into a burst register, and a 2-bit counter then steps through the other three words of the aligned group of four each time the advance input is sampled low. The burst order is selected by a mode input: linear increment or exclusive-or with the counter.

Reads come out either straight from the array in the cycle after the address edge (flow-through), or one cycle later through an output register (pipelined). A write is a global write of every lane or a byte write under a lane mask. Output enable and sleep act without the clock. Together with a deselect they clear the output-valid flag, which stands in for the tristate drivers. A deselect registered on an edge stops output in the very next data slot. Because the mode inputs have no pull-ups inside the core, the integrating design should tie them high to get the interleaved, pipelined default.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset `rst`, `rdata_vld` is low and no burst is active, so an advance with no strobe starts no access.
- R2: A cycle with `strb_cpu_n` low, `ce_n` low and both `ce2`/`ce3` at their active levels loads `addr` and reads it. The write inputs are ignored in that cycle.
- R3: A cycle with `strb_ctl_n` low (and no effective processor strobe) and all three enables active loads `addr`. It writes when a write is requested, and reads otherwise. A write is requested by `gw_n` low, or by `bwe_n` low together with at least one `lane_we_n` bit low.
- R4: In a byte write (`gw_n` high, `bwe_n` low), lane i (`wdata[8i+7:8i]`) is stored only when `lane_we_n[i]` is low. The other lanes keep their contents.
- R5: `gw_n` low writes all four lanes, whatever `bwe_n` and `lane_we_n` are.
- R6: In a cycle with no strobe while a burst is active, `adv_n` low steps the 2-bit counter, which wraps modulo 4. `adv_n` high repeats the current address. The address bits above bit 1 never change within a burst. Such a cycle writes when a write is requested and reads otherwise.
- R7: With `burst_il` low, address bits [1:0] are the start bits plus the counter, modulo 4. With `burst_il` high they are the start bits XOR the counter.
- R8: With `pipe_en` low, read data and `rdata_vld` appear in the cycle after the access edge. With `pipe_en` high they appear one cycle later.
- R9: While `ce_n` is high, a low `strb_cpu_n` is masked, and the cycle behaves as if that strobe were high.
- R10: `ce2`/`ce3` are examined only in strobe cycles. A strobe cycle with any enable inactive deselects and ends the burst, and continuation cycles ignore them.
- R11: A deselect or write cycle gives `rdata_vld` low in the data slot that a read on that edge would have used.
- R12: `oe_n` high forces `rdata_vld` low and `rdata` to zero at once, without waiting for a clock.
- R13: `sleep` high forces the output invalid without waiting for a clock. While it is high, sampled cycles neither read nor write, and the burst ends. Stored words are kept.
- R14: A new address can be loaded on every cycle, so back-to-back single reads yield one word per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of control state |
| addr | input | ADDR_W | Word address loaded by a strobe |
| ce_n | input | 1 | Active-low chip enable; masks the processor strobe |
| ce2 | input | 1 | Chip enable, active level CE2_ACT |
| ce3 | input | 1 | Chip enable, active level CE3_ACT |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 4*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| burst_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| pipe_en | input | 1 | Read path: 0 flow-through, 1 pipelined |
| rdata | output | 4*LANE_W | Read data, zero when not valid |
| rdata_vld | output | 1 | High when the data bus would be driven |

## Verification
The bench builds the block with its defaults: ADDR_W = 6 (64 words), 8-bit lanes, `ce2` active high and `ce3` active low. With 64 words, the whole array can be preloaded with distinct words, so every read has a known value. Bursts that start near the top of an aligned group of four then show wrap-around in both orders, with the upper address bits held. The fixed enable polarities let deselects be produced on either qualifying enable, both in flow-through and in pipelined mode.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int unsigned NLANES = 4;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleave);
        return interleave ? (start ^ step) : (start + step);
    endfunction

    // Lanes to be written this cycle; global write wins over the byte controls.
    function automatic logic [NLANES-1:0] lane_mask(input logic              gw_n,
                                                    input logic              bwe_n,
                                                    input logic [NLANES-1:0] lane_n);
        if (!gw_n)       return '1;
        else if (!bwe_n) return ~lane_n;
        else             return '0;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter bit          CE2_ACT = 1'b1,
    parameter bit          CE3_ACT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NLANES-1:0] lane_we_n,
    input  logic              burst_il,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [NLANES-1:0] cur_mask
);

    logic              active_q, active_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;
    logic [NLANES-1:0] req_mask;
    logic              cpu_go, ctl_go, side_sel;

    always_comb begin
        req_mask = lane_mask(gw_n, bwe_n, lane_we_n);
        cpu_go   = !strb_cpu_n && !ce_n;
        ctl_go   = !cpu_go && !strb_ctl_n;
        side_sel = (ce2 == CE2_ACT) && (ce3 == CE3_ACT);

        active_d = active_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        cur_op   = OP_NONE;
        cur_mask = '0;
        cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, burst_il)};

        if (sleep) begin
            active_d = 1'b0;
        end else if (cpu_go || ctl_go) begin
            if (!ce_n && side_sel) begin
                active_d = 1'b1;
                base_d   = addr;
                cnt_d    = 2'd0;
                cur_addr = addr;
                if (ctl_go && (|req_mask)) begin
                    cur_op   = OP_WR;
                    cur_mask = req_mask;
                end else begin
                    cur_op = OP_RD;
                end
            end else begin
                active_d = 1'b0;
            end
        end else if (active_q) begin
            if (!adv_n) cnt_d = cnt_q + 2'd1;
            cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_d, burst_il)};
            if (|req_mask) begin
                cur_op   = OP_WR;
                cur_mask = req_mask;
            end else begin
                cur_op = OP_RD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= 2'd0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            cnt_q    <= cnt_d;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DEPTH = 1 << ADDR_W,
    localparam int unsigned DW    = NLANES * LANE_W
) (
    input  logic              clk,
    input  logic [NLANES-1:0] wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g]) bank[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/bsram_outq.sv
module bsram_outq #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              pipe_en,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     q,
    output logic              q_vld
);

    logic              s1_vld, s2_vld;
    logic [ADDR_W-1:0] s1_addr;
    logic [DW-1:0]     s2_data;
    logic              pick_vld;
    logic [DW-1:0]     pick_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s2_vld <= 1'b0;
        end else begin
            s1_vld <= acc_rd;
            s2_vld <= s1_vld;
        end
        s1_addr <= acc_addr;
        s2_data <= rd_data;
    end

    assign rd_addr = s1_addr;

    always_comb begin
        pick_vld  = pipe_en ? s2_vld  : s1_vld;
        pick_data = pipe_en ? s2_data : rd_data;
        q_vld     = pick_vld && !oe_n && !sleep;
        q         = q_vld ? pick_data : '0;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned LANE_W  = 8,
    parameter bit          CE2_ACT = 1'b1,
    parameter bit          CE3_ACT = 1'b0,
    localparam int unsigned DW     = NLANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NLANES-1:0] lane_we_n,
    input  logic [DW-1:0]     wdata,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              burst_il,
    input  logic              pipe_en,
    output logic [DW-1:0]     rdata,
    output logic              rdata_vld
);

    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr, rd_addr;
    logic [NLANES-1:0] cur_mask;
    logic [DW-1:0]     rd_data;

    bsram_ctrl #(.ADDR_W(ADDR_W), .CE2_ACT(CE2_ACT), .CE3_ACT(CE3_ACT)) u_ctrl (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr),
        .ce_n(ce_n), .ce2(ce2), .ce3(ce3),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .burst_il(burst_il),
        .cur_op(cur_op), .cur_addr(cur_addr), .cur_mask(cur_mask)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
        .clk(clk), .wr_mask(cur_mask), .wr_addr(cur_addr), .wdata(wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    bsram_outq #(.ADDR_W(ADDR_W), .DW(DW)) u_outq (
        .clk(clk), .rst(rst), .acc_rd(cur_op == OP_RD), .acc_addr(cur_addr),
        .pipe_en(pipe_en), .oe_n(oe_n), .sleep(sleep),
        .rd_addr(rd_addr), .rd_data(rd_data), .q(rdata), .q_vld(rdata_vld)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter bit CE2_ACT = 1'b1,
    parameter bit CE3_ACT = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic ce2,
    input logic ce3,
    input logic strb_cpu_n,
    input logic strb_ctl_n,
    input logic gw_n,
    input logic pipe_en,
    input logic oe_n,
    input logic sleep,
    input logic rdata_vld
);

    logic both_sel;
    assign both_sel = (ce2 == CE2_ACT) && (ce3 == CE3_ACT);

    // R10
    desel_flow_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_en && !sleep && !strb_cpu_n && !ce_n && !both_sel) |=> !rdata_vld);

    // R11
    desel_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_en && !sleep && !strb_cpu_n && !ce_n && !both_sel) |=> ##1 !rdata_vld);

    // R11
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_en && !sleep && strb_cpu_n && !strb_ctl_n && !ce_n && both_sel && !gw_n)
        |=> !rdata_vld);

    // R13
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep && !pipe_en) |=> !rdata_vld);

    // R8
    flow_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_en && !sleep && !strb_cpu_n && !ce_n && both_sel)
        |=> (rdata_vld || oe_n || sleep));

    // R12
    always_comb begin
        if (!rst) begin
            oe_float_chk: assert (!(oe_n && rdata_vld));
        end
    end

endmodule

bind burst_sram burst_sram_chk #(.CE2_ACT(CE2_ACT), .CE3_ACT(CE3_ACT)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .ce2(ce2), .ce3(ce3),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .gw_n(gw_n),
    .pipe_en(pipe_en), .oe_n(oe_n), .sleep(sleep), .rdata_vld(rdata_vld)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr;
    logic        ce_n, ce2, ce3, strb_cpu_n, strb_ctl_n, adv_n, gw_n, bwe_n;
    logic [3:0]  lane_we_n;
    logic [31:0] wdata;
    logic        oe_n, sleep, burst_il, pipe_en;
    logic [31:0] rdata;
    logic        rdata_vld;

    burst_sram i_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .ce2(ce2), .ce3(ce3),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .burst_il(burst_il), .pipe_en(pipe_en),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";

    // Behavioural reference state
    logic [31:0] ref_mem [64];
    bit          r_active;
    int          r_base, r_cnt;
    bit          e1_v, e2_v;
    logic [31:0] e1_d, e2_d;

    task automatic model_step();
        int   kind, a, low;
        bit   do_rd, do_wr;
        logic [3:0] m;
        if (rst) begin
            r_active = 0; e1_v = 0; e2_v = 0;
            return;
        end
        e2_v = e1_v; e2_d = e1_d;
        do_rd = 0; do_wr = 0; a = 0;
        if (!gw_n)       m = 4'hF;
        else if (!bwe_n) m = ~lane_we_n;
        else             m = 4'h0;
        if (!strb_cpu_n && !ce_n) kind = 1;
        else if (!strb_ctl_n)     kind = 2;
        else                      kind = 0;
        if (sleep) begin
            r_active = 0;
        end else if (kind != 0) begin
            if (!ce_n && ce2 && !ce3) begin
                r_active = 1; r_base = int'(addr); r_cnt = 0; a = int'(addr);
                if (kind == 2 && m != 0) do_wr = 1; else do_rd = 1;
            end else begin
                r_active = 0;
            end
        end else if (r_active) begin
            if (!adv_n) r_cnt = (r_cnt + 1) % 4;
            low = burst_il ? ((r_base % 4) ^ r_cnt) : (((r_base % 4) + r_cnt) % 4);
            a = (r_base / 4) * 4 + low;
            if (m != 0) do_wr = 1; else do_rd = 1;
        end
        e1_v = do_rd;
        if (do_rd) e1_d = ref_mem[a];
        if (do_wr) begin
            for (int i = 0; i < 4; i++)
                if (m[i]) ref_mem[a][i*8 +: 8] = wdata[i*8 +: 8];
        end
    endtask

    task automatic compare();
        bit          ev;
        logic [31:0] ed;
        ev = (pipe_en ? e2_v : e1_v) && !oe_n && !sleep;
        ed = ev ? (pipe_en ? e2_d : e1_d) : 32'h0;
        tests++;
        if (rdata_vld !== ev || rdata !== ed) begin
            fails++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     cur_req, rdata_vld, rdata, ev, ed);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
        lane_we_n = 4'hF; ce_n = 0; ce2 = 1; ce3 = 0;
    endtask

    task automatic idle(int n);
        quiet();
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cpu_rd(int a);
        quiet(); addr = 6'(a); strb_cpu_n = 0; tick();
    endtask

    task automatic ctl_acc(int a, logic g_n, logic b_n, logic [3:0] ln, logic [31:0] d);
        quiet(); addr = 6'(a); strb_ctl_n = 0; gw_n = g_n; bwe_n = b_n;
        lane_we_n = ln; wdata = d; tick();
    endtask

    task automatic cont(logic adv, logic g_n, logic b_n, logic [3:0] ln, logic [31:0] d);
        quiet(); adv_n = adv; gw_n = g_n; bwe_n = b_n; lane_we_n = ln; wdata = d; tick();
    endtask

    task automatic burst_rd(int a);
        cpu_rd(a);
        for (int i = 0; i < 4; i++) cont(0, 1, 1, 4'hF, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1; quiet(); addr = 0; wdata = 0; oe_n = 0; sleep = 0;
        burst_il = 0; pipe_en = 0;
        for (int i = 0; i < 64; i++) ref_mem[i] = 32'h0;
        idle(3);
        rst = 0;

        cur_req = "R1";
        idle(2);
        cont(0, 1, 1, 4'hF, 32'h0);
        cont(0, 1, 1, 4'hF, 32'h0);

        cur_req = "R5";
        for (int i = 0; i < 64; i++)
            ctl_acc(i, 0, i[0], 4'(i), 32'hC3000000 ^ (i * 32'h01030507));
        idle(1);

        cur_req = "R14";
        cpu_rd(10); cpu_rd(11); cpu_rd(40); cpu_rd(3); cpu_rd(63);
        idle(2);

        cur_req = "R2";
        quiet(); addr = 12; strb_cpu_n = 0; gw_n = 0; wdata = 32'hDEADBEEF; tick();
        idle(1); cpu_rd(12); idle(1);

        cur_req = "R4";
        ctl_acc(20, 1, 0, 4'b1010, 32'h11223344);
        ctl_acc(21, 1, 0, 4'b0111, 32'hAABBCCDD);
        idle(1); cpu_rd(20); cpu_rd(21); idle(1);

        cur_req = "R3";
        ctl_acc(22, 1, 1, 4'b0000, 32'h55555555);
        idle(1); cpu_rd(22); idle(1);

        cur_req = "R5";
        ctl_acc(23, 0, 1, 4'hF, 32'h0BADF00D);
        idle(1); cpu_rd(23); idle(1);

        cur_req = "R6";
        burst_il = 0;
        burst_rd(5);
        idle(1);
        cpu_rd(13); cont(1, 1, 1, 4'hF, 0); cont(0, 1, 1, 4'hF, 0);
        cont(1, 1, 1, 4'hF, 0); cont(0, 1, 1, 4'hF, 0);
        idle(1);
        ctl_acc(32, 0, 1, 4'hF, 32'h01020304);
        cont(0, 0, 1, 4'hF, 32'h05060708);
        cont(0, 1, 0, 4'b1100, 32'h090A0B0C);
        idle(1); burst_rd(32); idle(1);

        cur_req = "R7";
        burst_il = 1;
        burst_rd(6);
        idle(1);
        burst_rd(45);
        idle(1);

        cur_req = "R9";
        burst_il = 0;
        cpu_rd(17);
        quiet(); ce_n = 1; strb_cpu_n = 0; adv_n = 0; addr = 50; tick();
        cont(0, 1, 1, 4'hF, 0);
        idle(1);

        cur_req = "R10";
        cpu_rd(25);
        quiet(); ce2 = 0; ce3 = 1; adv_n = 0; tick();
        quiet(); strb_cpu_n = 0; ce2 = 0; addr = 30; adv_n = 0; tick();
        cont(0, 1, 1, 4'hF, 0);
        quiet(); strb_ctl_n = 0; ce_n = 1; addr = 31; gw_n = 0; wdata = 32'hFFFF0000; tick();
        idle(1); cpu_rd(31); idle(1);

        cur_req = "R11";
        cpu_rd(2);
        quiet(); strb_cpu_n = 0; ce3 = 1; addr = 4; tick();
        cpu_rd(8);
        idle(2);

        cur_req = "R8";
        pipe_en = 1;
        idle(2);
        cpu_rd(1); cpu_rd(2); cpu_rd(60);
        burst_rd(9);
        ctl_acc(14, 0, 1, 4'hF, 32'h12345678);
        cpu_rd(14);
        idle(3);

        cur_req = "R11";
        cpu_rd(18);
        quiet(); strb_cpu_n = 0; ce2 = 0; addr = 19; tick();
        cpu_rd(19);
        idle(3);

        cur_req = "R12";
        pipe_en = 0;
        idle(2);
        cpu_rd(27);
        oe_n = 1; #1 compare();
        cont(0, 1, 1, 4'hF, 0);
        oe_n = 0; #1 compare();
        cont(0, 1, 1, 4'hF, 0);
        idle(1);

        cur_req = "R13";
        cpu_rd(28);
        sleep = 1; #1 compare();
        ctl_acc(7, 0, 1, 4'hF, 32'h77777777);
        cont(0, 1, 1, 4'hF, 0);
        sleep = 0;
        cont(0, 1, 1, 4'hF, 0);
        idle(1); cpu_rd(7); cpu_rd(28); idle(2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule